// File: doc/BRIEF.md
# Dual elapsed seconds counter

This block keeps two 32-bit counts of whole seconds, and both are driven by one shared 1 Hz tick strobe. The first lane is the run-time lane, and it advances on every tick. The second lane is the supplied-time lane. It advances only while a digital "main supply good" flag is high, and it holds its value while the flag is low. Software, or a serial front end placed outside this block, can clear either lane to zero. It can also load either lane with a 32-bit word, and all 32 bits are applied in one cycle.

A lane is read through a snapshot register. A capture strobe copies the chosen lane into this register. A shifter outside the block can then read the register bit by bit while the live counts keep advancing, and it never sees a value that changed partway through the read. Each lane gives clear priority over load, and load priority over count. Both lanes wrap silently from all-ones to zero.

Top module: `dual_secs_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, both lanes and `snap_o` become zero.
- R2: The run-time lane adds one at each edge where `tick_i` is high, whatever the value of `supply_ok_i`.
- R3: The supplied-time lane adds one at an edge where both `tick_i` and `supply_ok_i` are high. When `supply_ok_i` is low, the lane keeps its value.
- R4: At an edge where `snap_i` is high, `snap_o` takes the value the selected lane held before that edge. `snap_sel_i` = 0 selects the run-time lane and 1 selects the supplied-time lane. At every other edge, `snap_o` keeps its value.
- R5: A load strobe (`load_run_i` or `load_sup_i`) writes all 32 bits of `load_word_i` into its lane at that edge. A tick in the same cycle is dropped for that lane.
- R6: A clear strobe (`clr_run_i` or `clr_sup_i`) sets its lane to zero at that edge. It wins over a load in the same cycle, and both lanes may be cleared in the same cycle.
- R7: A lane that holds all-ones and counts goes to zero. No flag is raised.
- R8: The clear and load strobes of one lane have no effect on the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle seconds tick |
| supply_ok_i | input | 1 | Main supply good; enables the supplied-time lane |
| clr_run_i | input | 1 | Clear the run-time lane |
| clr_sup_i | input | 1 | Clear the supplied-time lane |
| load_run_i | input | 1 | Load the run-time lane |
| load_sup_i | input | 1 | Load the supplied-time lane |
| load_word_i | input | 32 | Parallel load value |
| snap_i | input | 1 | Capture the selected lane into the snapshot |
| snap_sel_i | input | 1 | Lane select: 0 run-time, 1 supplied-time |
| snap_o | output | 32 | Snapshot register |

## Verification
The hardest situation to reach from the ports is one cycle that combines a capture, a tick, a change of the supply flag and the clear and load strobes. In that cycle the snapshot must return the pre-edge value, while every lane resolves its own priority. Before each such cycle, the bench preloads both lanes to known values, and for half of the cases those values are all-ones. It then sweeps all 128 combinations of tick, supply flag, the two clears, the two loads and the lane select, with a capture in the same cycle. Afterwards it reads both lanes back through the snapshot and compares them with values it computes from the requirements.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic {
        LANE_RUN = 1'b0,
        LANE_SUP = 1'b1
    } lane_e;

    localparam int unsigned N_LANES = 2;
endpackage

// File: rtl/secs_lane.sv
module secs_lane #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_word_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } lane_state_t;

    lane_state_t state_d, state_q;

    // priority: clear, then load, then count
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.count = '0;
        end else if (load_i) begin
            state_d.count = load_word_i;
        end else if (inc_i) begin
            state_d.count = state_q.count + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.count;
endmodule

// File: rtl/snap_latch.sv
module snap_latch #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned N_LANES = 2,
    localparam int unsigned SEL_W  = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snap_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CNT_W-1:0] lane_cnt_i [N_LANES],
    output logic [CNT_W-1:0] snap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] value;
    } snap_state_t;

    snap_state_t state_d, state_q;
    logic [CNT_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < N_LANES; i++) begin
            if (sel_i == SEL_W'(i)) begin
                picked = lane_cnt_i[i];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (snap_i) begin
            state_d.value = picked;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign snap_o = state_q.value;
endmodule

// File: rtl/dual_secs_counter.sv
module dual_secs_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             supply_ok_i,
    input  logic             clr_run_i,
    input  logic             clr_sup_i,
    input  logic             load_run_i,
    input  logic             load_sup_i,
    input  logic [CNT_W-1:0] load_word_i,
    input  logic             snap_i,
    input  logic             snap_sel_i,
    output logic [CNT_W-1:0] snap_o
);
    import dsc_pkg::*;

    logic [CNT_W-1:0] lane_cnt [N_LANES];
    logic [N_LANES-1:0] lane_en, lane_clr, lane_load;

    assign lane_clr[LANE_RUN]  = clr_run_i;
    assign lane_clr[LANE_SUP]  = clr_sup_i;
    assign lane_load[LANE_RUN] = load_run_i;
    assign lane_load[LANE_SUP] = load_sup_i;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        if (g == int'(LANE_RUN)) begin : g_always
            assign lane_en[g] = 1'b1;
        end else begin : g_gated
            assign lane_en[g] = supply_ok_i;
        end

        secs_lane #(.CNT_W(CNT_W)) lane_i (
            .clk         (clk),
            .rst         (rst),
            .inc_i       (tick_i & lane_en[g]),
            .clr_i       (lane_clr[g]),
            .load_i      (lane_load[g]),
            .load_word_i (load_word_i),
            .count_o     (lane_cnt[g])
        );
    end

    snap_latch #(.CNT_W(CNT_W), .N_LANES(N_LANES)) snap_i0 (
        .clk        (clk),
        .rst        (rst),
        .snap_i     (snap_i),
        .sel_i      (snap_sel_i),
        .lane_cnt_i (lane_cnt),
        .snap_o     (snap_o)
    );

    logic [CNT_W-1:0] run_cnt_w, sup_cnt_w;
    assign run_cnt_w = lane_cnt[LANE_RUN];
    assign sup_cnt_w = lane_cnt[LANE_SUP];
endmodule

// File: rtl/dual_secs_counter_chk.sv
module dual_secs_counter_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             supply_ok_i,
    input logic             clr_run_i,
    input logic             clr_sup_i,
    input logic             load_run_i,
    input logic             load_sup_i,
    input logic [CNT_W-1:0] load_word_i,
    input logic             snap_i,
    input logic             snap_sel_i,
    input logic [CNT_W-1:0] snap_o,
    input logic [CNT_W-1:0] run_cnt,
    input logic [CNT_W-1:0] sup_cnt
);
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (snap_o == '0 && run_cnt == '0 && sup_cnt == '0));

    assert_run_counts_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !clr_run_i && !load_run_i) |=> run_cnt == CNT_W'($past(run_cnt) + 1'b1));

    assert_sup_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!supply_ok_i && !clr_sup_i && !load_sup_i) |=> $stable(sup_cnt));

    assert_snap_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !snap_i |=> $stable(snap_o));

    assert_snap_run_R4: assert property (@(posedge clk) disable iff (rst)
        (snap_i && !snap_sel_i) |=> snap_o == $past(run_cnt));

    assert_snap_sup_R4: assert property (@(posedge clk) disable iff (rst)
        (snap_i && snap_sel_i) |=> snap_o == $past(sup_cnt));

    assert_load_run_R5: assert property (@(posedge clk) disable iff (rst)
        (load_run_i && !clr_run_i) |=> run_cnt == $past(load_word_i));

    assert_clear_sup_R6: assert property (@(posedge clk) disable iff (rst)
        clr_sup_i |=> sup_cnt == '0);

    assert_clear_run_R6: assert property (@(posedge clk) disable iff (rst)
        clr_run_i |=> run_cnt == '0);
endmodule

bind dual_secs_counter dual_secs_counter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .clr_run_i   (clr_run_i),
    .clr_sup_i   (clr_sup_i),
    .load_run_i  (load_run_i),
    .load_sup_i  (load_sup_i),
    .load_word_i (load_word_i),
    .snap_i      (snap_i),
    .snap_sel_i  (snap_sel_i),
    .snap_o      (snap_o),
    .run_cnt     (run_cnt_w),
    .sup_cnt     (sup_cnt_w)
);

// File: tb/dual_secs_counter_tb.sv
module dual_secs_counter_tb_top;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 0, supply_ok_i = 0, clr_run_i = 0, clr_sup_i = 0;
    logic load_run_i = 0, load_sup_i = 0, snap_i = 0, snap_sel_i = 0;
    logic [W-1:0] load_word_i = '0;
    logic [W-1:0] snap_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [W-1:0] m_run, m_sup;

    always #4 clk = ~clk;

    dual_secs_counter #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
        .clr_run_i(clr_run_i), .clr_sup_i(clr_sup_i),
        .load_run_i(load_run_i), .load_sup_i(load_sup_i),
        .load_word_i(load_word_i), .snap_i(snap_i), .snap_sel_i(snap_sel_i),
        .snap_o(snap_o)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        tick_i = 0; clr_run_i = 0; clr_sup_i = 0;
        load_run_i = 0; load_sup_i = 0; snap_i = 0;
    endtask

    // one cycle with model update; inputs driven after a falling edge
    task automatic cyc(input logic t, input logic ok, input logic cr, input logic cs,
                       input logic lr, input logic ls, input logic [W-1:0] w,
                       input logic sn, input logic sel, output logic [W-1:0] exp_snap);
        logic [W-1:0] nr, ns;
        tick_i = t; supply_ok_i = ok; clr_run_i = cr; clr_sup_i = cs;
        load_run_i = lr; load_sup_i = ls; load_word_i = w;
        snap_i = sn; snap_sel_i = sel;
        exp_snap = sn ? (sel ? m_sup : m_run) : snap_o;
        nr = cr ? '0 : lr ? w : t ? m_run + 1 : m_run;
        ns = cs ? '0 : ls ? w : (t && ok) ? m_sup + 1 : m_sup;
        @(posedge clk);
        @(negedge clk);
        m_run = nr;
        m_sup = ns;
        idle();
    endtask

    task automatic read_lane(input logic sel, input string tag, input logic [W-1:0] exp);
        logic [W-1:0] es;
        cyc(0, supply_ok_i, 0, 0, 0, 0, '0, 1, sel, es);
        check(tag, snap_o, exp);
    endtask

    task automatic preload(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] es;
        cyc(0, 0, 0, 0, 1, 0, a, 0, 0, es);
        cyc(0, 0, 0, 0, 0, 1, b, 0, 0, es);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] es;
        m_run = '0; m_sup = '0;
        // R1: reset state, even after activity
        repeat (3) @(negedge clk);
        rst = 0;
        tick_i = 1; supply_ok_i = 1;
        repeat (5) @(negedge clk);
        idle();
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 snap after reset", snap_o, '0);
        read_lane(0, "R1 run lane after reset", '0);
        read_lane(1, "R1 sup lane after reset", '0);

        // R2/R3: run of ticks with supply toggling
        for (int i = 0; i < 20; i++) begin
            cyc(1, (i % 3) != 0, 0, 0, 0, 0, '0, 0, 0, es);
        end
        read_lane(0, "R2 run lane after ticks", 32'd20);
        read_lane(1, "R3 sup lane gated by supply", 32'd13);

        // R4: snapshot holds without strobe while lanes tick
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, '0, 0, 0, es);
        check("R4 snapshot holds without strobe", snap_o, 32'd13);

        // R7: wrap both lanes
        preload('1, '1);
        cyc(1, 1, 0, 0, 0, 0, '0, 0, 0, es);
        read_lane(0, "R7 run lane wraps", '0);
        read_lane(1, "R7 sup lane wraps", '0);

        // sweep of every strobe combination, capture in the same cycle
        for (int c = 0; c < 128; c++) begin
            logic [W-1:0] a, b, w;
            string tag;
            a = c[0] ? '1 : 32'h1234_5600 + W'(c);
            b = c[0] ? '1 : 32'h0BAD_0000 + W'(c);
            w = 32'hA5A5_0000 | W'(c);
            preload(a, b);
            cyc(c[1], c[2], c[3], c[4], c[5], c[6], w, 1, c[0], es);
            check("R4 capture returns pre-edge value", snap_o, es);
            tag = c[3] ? "R6 run clear" : c[5] ? "R5 run load" :
                  (c[1] && c[0]) ? "R7 run wrap" : "R2 run count";
            if (c[4] || c[6]) tag = {tag, " R8"};
            read_lane(0, tag, m_run);
            tag = c[4] ? "R6 sup clear" : c[6] ? "R5 sup load" :
                  !c[2] ? "R3 sup hold" : "R3 sup count";
            if (c[3] || c[5]) tag = {tag, " R8"};
            read_lane(1, tag, m_sup);
        end

        // R6: both clears together, with loads present
        preload(32'h55, 32'h66);
        cyc(1, 1, 1, 1, 1, 1, 32'h77, 0, 0, es);
        read_lane(0, "R6 both clear run", '0);
        read_lane(1, "R6 both clear sup", '0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule